// File: doc/BRIEF.md
# SRAM Power Mode Controller

This always-on controller places an embedded SRAM in one of three power states: active, deep-sleep or power-off. Two active-low request pins choose the state. Both pins pass through a two-flop synchroniser before they are decoded. In deep-sleep the controller opens every power-switch segment and turns the array regulator on. The array then keeps its contents at a reduced supply while the peripheral logic goes dark. In power-off both the switches and the regulator are off, so the stored data is lost.

On a return to active, the segments close one per clock, starting with the lowest index. This spreads the inrush current. A wake-done flag rises one cycle after the last segment is on, and only from then on are accesses granted. A mode change does not start while the memory reports an access in progress. While the regulator is on, the controller passes a two-bit reference-level select to a reference code output. While the regulator is off, it forces a full-supply code and turns the bias off.

Top module: `sram_pmc`

## Requirements
- R1: While `rst_n` is low, the controller holds power-off. The switch enables, `reg_en`, `wake_done` and `mem_grant` are all 0, and `ref_code` is 3'b100.
- R2: Decoding of the synchronised requests: with `off_n` low the target is power-off, whatever `sleep_n` is. With only `sleep_n` low the target is deep-sleep. With both high the target is active. A change on either pin first affects the state on the third rising edge after it. `pwr_mode` encodes active as 2'b00, deep-sleep as 2'b01, power-off as 2'b10 and waking as 2'b11.
- R3: In active mode every bit of `arr_sw_en` and of `per_sw_en` is 1, `reg_en` is 0 and `wake_done` is 1.
- R4: In deep-sleep every switch enable is 0, `reg_en` is 1 and `bias_en` is 1.
- R5: In power-off every switch enable is 0 and `reg_en` and `bias_en` are both 0.
- R6: While `reg_en` is 1, `ref_code` equals {1'b0, `lvl_sel`}: 00 selects 0.78, 01 selects 0.74, 10 selects 0.70 and 11 selects 0.64 of supply. `lvl_sel` is registered, so a change shows on `ref_code` one edge later. While `reg_en` is 0, `ref_code` is 3'b100 (full supply) and `bias_en` is 0, whatever `lvl_sel` is.
- R7: On wake-up the state is waking. On the k-th edge after the wake decision, segments 0..k-1 of both domains are enabled and the others are not.
- R8: `wake_done` rises exactly one edge after the last segment turns on, and never while any segment is off.
- R9: `mem_grant` is `mem_req` AND `wake_done` AND a synchronised target of active. It is 0 in deep-sleep, power-off and waking, and it falls as soon as a departure from active is pending.
- R10: While `mem_busy` is 1, the controller stays in active even when another mode is requested. The change takes effect on the first edge at which `mem_busy` is 0.
- R11: During a wake-up from deep-sleep, `reg_en` stays 1 until active is reached. During a wake-up from power-off it stays 0.
- R12: Deep-sleep and power-off switch directly into each other without passing through active. A request for a sleep mode during waking abandons the ramp and turns every segment off on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sleep_n | input | 1 | Deep-sleep request, active low, asynchronous |
| off_n | input | 1 | Power-off request, active low, asynchronous |
| lvl_sel | input | 2 | Regulator reference level select |
| mem_req | input | 1 | Read or write request from the memory client |
| mem_busy | input | 1 | An access is in progress in the memory |
| mem_grant | output | 1 | Access accepted |
| arr_sw_en | output | NSEG | Cell-array power-switch segment enables |
| per_sw_en | output | NSEG | Peripheral power-switch segment enables |
| reg_en | output | 1 | Array regulator enable |
| bias_en | output | 1 | Regulator bias enable |
| ref_code | output | 3 | Reference code; 3'b100 means full supply |
| pwr_mode | output | 2 | Current mode code |
| wake_done | output | 1 | All segments are on and accesses are allowed |

## Verification
A mode change and an access can meet in the same cycle. The bench provokes this by holding `mem_busy` while it requests power-off. It then judges that the state stays active for several cycles with the grant withdrawn, and that power-off begins on the edge after the busy signal drops. A second overlap is a new sleep request arriving during the segment ramp. The bench checks that the ramp stops at its partial count and that the next edge shows deep-sleep with every segment off and the regulator on.

// File: rtl/pmc_pkg.sv
`timescale 1ns/1ps
// Shared types for the SRAM power mode controller.
// Assumes: the mode code values are visible at the top-level pwr_mode port.
package pmc_pkg;
    typedef enum logic [1:0] {
        PM_ACT  = 2'b00,
        PM_DS   = 2'b01,
        PM_PO   = 2'b10,
        PM_WAKE = 2'b11
    } pm_mode_e;

    localparam logic [2:0] REF_FULL = 3'b100;
endpackage

// File: rtl/pmc_req_sync.sv
`timescale 1ns/1ps
// Synchronises the two active-low mode requests with two flops each,
// then decodes them into a target mode. Off takes priority over sleep.
// Assumes: the request pins are asynchronous to clk and level-held.
module pmc_req_sync
    import pmc_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     sleep_n,
    input  logic     off_n,
    output pm_mode_e tgt_o
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] slp_sh;
    logic [STAGES-1:0] off_sh;

    // shift chains; reset to the idle (no request) level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slp_sh <= '1;
            off_sh <= '1;
        end else begin
            slp_sh <= {slp_sh[STAGES-2:0], sleep_n};
            off_sh <= {off_sh[STAGES-2:0], off_n};
        end
    end

    // priority decode of the synchronised levels
    always_comb begin
        if (!off_sh[LAST])       tgt_o = PM_PO;
        else if (!slp_sh[LAST])  tgt_o = PM_DS;
        else                     tgt_o = PM_ACT;
    end

    // R2: power-off target only after the pin was low two edges earlier
    a_r2_off_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_o == PM_PO) |-> !$past(off_n, 2));
endmodule

// File: rtl/pmc_mode_fsm.sv
`timescale 1ns/1ps
// Mode state machine: holds the current mode, steps the segment count
// during wake-up and drives the regulator enable.
// Assumes: tgt never carries PM_WAKE; mem_busy marks an access in progress.
module pmc_mode_fsm
    import pmc_pkg::*;
#(
    parameter int NSEG = 8,
    parameter int CW   = $clog2(NSEG + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  pm_mode_e      tgt,
    input  logic          mem_busy,
    output pm_mode_e      st_o,
    output logic [CW-1:0] cnt_o,
    output logic          reg_en_o
);
    pm_mode_e      st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          fds_q, fds_d;
    logic          reg_d;

    // next-state and segment-count computation
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        fds_d = fds_q;
        unique case (st_q)
            PM_ACT: begin
                if (tgt != PM_ACT && !mem_busy) begin
                    st_d  = tgt;
                    cnt_d = '0;
                end
            end
            PM_DS, PM_PO: begin
                if (tgt == PM_ACT) begin
                    st_d  = PM_WAKE;
                    cnt_d = CW'(1);
                    fds_d = (st_q == PM_DS);
                end else begin
                    st_d = tgt;
                end
            end
            PM_WAKE: begin
                if (tgt != PM_ACT) begin
                    st_d  = tgt;
                    cnt_d = '0;
                end else if (cnt_q == CW'(NSEG)) begin
                    st_d = PM_ACT;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: st_d = PM_PO;
        endcase
    end

    // regulator on in deep-sleep and while waking out of deep-sleep
    always_comb reg_d = (st_d == PM_DS) || (st_d == PM_WAKE && fds_d);

    // state registers; reset lands in power-off
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= PM_PO;
            cnt_q    <= '0;
            fds_q    <= 1'b0;
            reg_en_o <= 1'b0;
        end else begin
            st_q     <= st_d;
            cnt_q    <= cnt_d;
            fds_q    <= fds_d;
            reg_en_o <= reg_d;
        end
    end

    assign st_o  = st_q;
    assign cnt_o = cnt_q;

    // R7: the ramp adds exactly one segment per cycle
    a_r7_one_step: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == PM_WAKE && $past(st_q) == PM_WAKE) |-> cnt_q == $past(cnt_q) + 1'b1);
    // R10: a busy access keeps the block in active
    a_r10_hold_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == PM_ACT && mem_busy) |=> st_q == PM_ACT);
    // R12: a sleep mode is never followed directly by active
    a_r12_no_skip: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == PM_DS || st_q == PM_PO) |=> st_q != PM_ACT);
endmodule

// File: rtl/pmc_sw_ramp.sv
`timescale 1ns/1ps
// Turns the segment count into thermometer enables for both domains.
// Assumes: count never exceeds NSEG.
module pmc_sw_ramp #(
    parameter int NSEG = 8,
    parameter int CW   = $clog2(NSEG + 1)
) (
    input  logic [CW-1:0]   cnt,
    output logic [NSEG-1:0] arr_en,
    output logic [NSEG-1:0] per_en
);
    for (genvar i = 0; i < NSEG; i++) begin : g_seg
        assign arr_en[i] = (cnt > CW'(i));
        assign per_en[i] = (cnt > CW'(i));
    end
endmodule

// File: rtl/pmc_ref_ctrl.sv
`timescale 1ns/1ps
// Reference/bias selection: passes the registered level select while the
// regulator runs, and forces full-supply reference and bias off otherwise.
// Assumes: lvl_sel is quasi-static.
module pmc_ref_ctrl
    import pmc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] lvl_sel,
    input  logic       reg_en,
    output logic [2:0] ref_code,
    output logic       bias_en
);
    logic [1:0] lvl_q;

    // capture the level select
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_q <= '0;
        else        lvl_q <= lvl_sel;
    end

    // forced safe selection when the regulator is off
    always_comb begin
        ref_code = reg_en ? {1'b0, lvl_q} : REF_FULL;
        bias_en  = reg_en;
    end
endmodule

// File: rtl/sram_pmc.sv
`timescale 1ns/1ps
// Top of the SRAM power mode controller: synchroniser, mode FSM,
// segment ramp and reference control, plus the access gate.
// Assumes: it sits on the always-on supply; mem_busy comes from the memory.
module sram_pmc
    import pmc_pkg::*;
#(
    parameter int NSEG = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sleep_n,
    input  logic            off_n,
    input  logic [1:0]      lvl_sel,
    input  logic            mem_req,
    input  logic            mem_busy,
    output logic            mem_grant,
    output logic [NSEG-1:0] arr_sw_en,
    output logic [NSEG-1:0] per_sw_en,
    output logic            reg_en,
    output logic            bias_en,
    output logic [2:0]      ref_code,
    output logic [1:0]      pwr_mode,
    output logic            wake_done
);
    localparam int CW = $clog2(NSEG + 1);

    pm_mode_e      tgt;
    pm_mode_e      st;
    logic [CW-1:0] cnt;

    pmc_req_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .sleep_n(sleep_n), .off_n(off_n), .tgt_o(tgt)
    );

    pmc_mode_fsm #(.NSEG(NSEG), .CW(CW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .tgt(tgt), .mem_busy(mem_busy),
        .st_o(st), .cnt_o(cnt), .reg_en_o(reg_en)
    );

    pmc_sw_ramp #(.NSEG(NSEG), .CW(CW)) u_ramp (
        .cnt(cnt), .arr_en(arr_sw_en), .per_en(per_sw_en)
    );

    pmc_ref_ctrl u_ref (
        .clk(clk), .rst_n(rst_n), .lvl_sel(lvl_sel), .reg_en(reg_en),
        .ref_code(ref_code), .bias_en(bias_en)
    );

    // access gate and mode reporting
    always_comb begin
        wake_done = (st == PM_ACT);
        mem_grant = mem_req && wake_done && (tgt == PM_ACT);
        pwr_mode  = st;
    end

    // R9: a grant only with every segment on and the regulator off
    a_r9_grant_safe: assert property (@(posedge clk) disable iff (!rst_n)
        mem_grant |-> (&arr_sw_en) && (&per_sw_en) && !reg_en);
    // R8: wake-done never while any segment is off
    a_r8_done_full: assert property (@(posedge clk) disable iff (!rst_n)
        wake_done |-> (&arr_sw_en) && (&per_sw_en));
    // R4: deep-sleep has every switch open and the regulator on
    a_r4_ds_open: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_mode == PM_DS) |-> (arr_sw_en == '0) && (per_sw_en == '0) && reg_en);
    // R6: regulator off forces full-supply reference and no bias
    a_r6_ref_forced: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_en |-> (ref_code == REF_FULL) && !bias_en);
endmodule

// File: tb/sram_pmc_tb_top.sv
`timescale 1ns/1ps
module sram_pmc_tb_top;
    import pmc_pkg::*;

    localparam int NSEG = 8;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            sleep_n, off_n, mem_req, mem_busy;
    logic [1:0]      lvl_sel;
    logic            mem_grant, reg_en, bias_en, wake_done;
    logic [NSEG-1:0] arr_sw_en, per_sw_en;
    logic [2:0]      ref_code;
    logic [1:0]      pwr_mode;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    bit done  = 1'b0;

    typedef struct {
        int         cyc;
        string      tag;
        logic [1:0] mode;
        int         k;
        logic       r;
        logic [2:0] rc;
        logic       wd;
        logic       g;
    } exp_t;

    exp_t q[$];
    exp_t e;

    sram_pmc #(.NSEG(NSEG)) dut_i (
        .clk(clk), .rst_n(rst_n), .sleep_n(sleep_n), .off_n(off_n),
        .lvl_sel(lvl_sel), .mem_req(mem_req), .mem_busy(mem_busy),
        .mem_grant(mem_grant), .arr_sw_en(arr_sw_en), .per_sw_en(per_sw_en),
        .reg_en(reg_en), .bias_en(bias_en), .ref_code(ref_code),
        .pwr_mode(pwr_mode), .wake_done(wake_done)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [NSEG-1:0] therm(int k);
        logic [NSEG-1:0] v = '0;
        for (int i = 0; i < NSEG; i++) if (i < k) v[i] = 1'b1;
        return v;
    endfunction

    // driver side: push an expectation for dc edges from now
    task automatic expect_at(string tag, int dc, logic [1:0] m, int k,
                             logic r, logic [2:0] rc, logic wd, logic g);
        exp_t x;
        x.cyc = cyc + dc; x.tag = tag; x.mode = m; x.k = k;
        x.r = r; x.rc = rc; x.wd = wd; x.g = g;
        q.push_back(x);
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor: compare outputs 5 ns after each edge
    always @(posedge clk) begin
        #5;
        while (q.size() > 0 && q[0].cyc <= cyc) begin
            logic [2*NSEG+8:0] act, exv;
            e = q.pop_front();
            act = {pwr_mode, arr_sw_en, per_sw_en, reg_en, bias_en, ref_code, wake_done, mem_grant};
            exv = {e.mode, therm(e.k), therm(e.k), e.r, e.r, e.rc, e.wd, e.g};
            total++;
            if (act !== exv) begin
                bad++;
                $display("FAIL %s cyc=%0d actual=%h expected=%h", e.tag, cyc, act, exv);
            end
        end
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; sleep_n = 1'b1; off_n = 1'b1;
        lvl_sel = 2'd0; mem_req = 1'b1; mem_busy = 1'b0;
        step(3);
        expect_at("R1 reset", 1, PM_PO, 0, 0, 3'b100, 0, 0);
        step(1);
        rst_n = 1'b1;
        // R7 R11 ramp out of reset power-off, regulator stays off
        for (int k = 1; k <= NSEG; k++)
            expect_at("R7 R11 ramp from off", k, PM_WAKE, k, 0, 3'b100, 0, 0);
        expect_at("R3 R8 R9 active", NSEG + 1, PM_ACT, NSEG, 0, 3'b100, 1, 1);
        step(NSEG + 2);

        // R2 R4 R6 R9 deep-sleep entry
        sleep_n = 1'b0; lvl_sel = 2'd2;
        expect_at("R9 pending departure", 2, PM_ACT, NSEG, 0, 3'b100, 1, 0);
        expect_at("R2 R4 R6 deep-sleep", 3, PM_DS, 0, 1, 3'b010, 0, 0);
        step(3);
        lvl_sel = 2'd3;
        expect_at("R6 level change", 1, PM_DS, 0, 1, 3'b011, 0, 0);
        step(2);

        // R2 R5 R12 both low selects power-off, direct from deep-sleep
        off_n = 1'b0;
        expect_at("R2 R5 R12 ds to off", 3, PM_PO, 0, 0, 3'b100, 0, 0);
        step(4);
        off_n = 1'b1;
        expect_at("R12 off to ds", 3, PM_DS, 0, 1, 3'b011, 0, 0);
        step(4);

        // R7 R11 wake from deep-sleep keeps regulator on
        sleep_n = 1'b1;
        for (int k = 1; k <= NSEG; k++)
            expect_at("R7 R11 ramp from ds", 2 + k, PM_WAKE, k, 1, 3'b011, 0, 0);
        expect_at("R3 R8 active again", NSEG + 3, PM_ACT, NSEG, 0, 3'b100, 1, 1);
        step(NSEG + 4);

        // R10 busy defers power-off
        mem_busy = 1'b1; off_n = 1'b0;
        expect_at("R10 held by busy", 3, PM_ACT, NSEG, 0, 3'b100, 1, 0);
        expect_at("R10 still held", 6, PM_ACT, NSEG, 0, 3'b100, 1, 0);
        step(6);
        mem_busy = 1'b0;
        expect_at("R10 released", 1, PM_PO, 0, 0, 3'b100, 0, 0);
        step(2);

        // R12 sleep request aborts a ramp
        off_n = 1'b1;
        expect_at("R7 abort ramp k1", 3, PM_WAKE, 1, 0, 3'b100, 0, 0);
        expect_at("R7 abort ramp k3", 5, PM_WAKE, 3, 0, 3'b100, 0, 0);
        step(3);
        sleep_n = 1'b0;
        expect_at("R12 ramp abandoned", 3, PM_DS, 0, 1, 3'b011, 0, 0);
        step(5);

        // R9 no request, no grant
        mem_req = 1'b0; sleep_n = 1'b1;
        expect_at("R11 ramp k3", 5, PM_WAKE, 3, 1, 3'b011, 0, 0);
        expect_at("R9 no request", NSEG + 3, PM_ACT, NSEG, 0, 3'b100, 1, 0);
        step(NSEG + 6);
        mem_req = 1'b1;
        expect_at("R9 request granted", 1, PM_ACT, NSEG, 0, 3'b100, 1, 1);
        step(4);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule